// File: doc/BRIEF.md
# Video Multiplexer Select Sequencer

This block drives the select lines of an analog input multiplexer that steers three colour video inputs (red, green, blue) onto three sampling lanes. It also drives the selector of a pair of sample-and-hold banks: while one bank captures the current line, the other drives the panel. Every falling edge of the inhibit input marks a line boundary. On that edge the select counters step, the active bank swaps, and a new routing pattern is produced.

The routing pattern depends on the colour-filter arrangement, which is chosen by a 2-bit pattern input and captured at each line boundary. After reset the multiplexer is off and sampling is disabled. The sequencer is armed by the first falling edge of the inhibit input and stays armed until the next reset.

The inhibit input is asynchronous to the clock. It passes through a synchronizer of `SYNC_STAGES` flops before its falling edge is detected.

Top module: `vmx_select_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three route codes become 3 (multiplexer off), `bank_sel_o` becomes 0 and `sample_en_o` becomes 0.
- R2: Until the first falling edge of `inh_i` after reset, the route codes stay 3, `bank_sel_o` stays 0 and `sample_en_o` stays 0. A rising edge of `inh_i` alone changes nothing.
- R3: `sample_en_o` goes high on the first falling edge of `inh_i` and then stays high until reset.
- R4: `bank_sel_o` inverts on every falling edge of `inh_i` and holds between edges.
- R5: Pattern code 0 (stripe): red→lane 0, green→lane 1, blue→lane 2 on every line.
- R6: Pattern code 2 (mosaic): after the n-th falling edge since reset, colour c (red=0, green=1, blue=2) routes to lane (c+n) mod 3. The three lanes are always distinct.
- R7: Pattern code 1 (one-sided delta): colour c routes to lane c when n is even and to lane (c+1) mod 3 when n is odd.
- R8: Pattern code 3 (two-sided delta): with n mod 4 = 0 or 2, colour c routes to lane c. With n mod 4 = 1 it routes to (c+1) mod 3, and with n mod 4 = 3 it routes to (c+2) mod 3.
- R9: The pattern input is sampled only at a falling edge of `inh_i`. Changing it between edges leaves the route codes unchanged until the next edge.
- R10: A falling edge of `inh_i` takes effect at the (`SYNC_STAGES`+1)-th rising clock edge after `inh_i` is first sampled low. Outputs are unchanged before that edge.
- R11: A reset in mid-run restores the R1 state, and line counting restarts, so the next falling edge is n = 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inh_i | input | 1 | Inhibit pulse; its falling edge ends a line (asynchronous) |
| pat_sel_i | input | 2 | Colour-filter arrangement: 0 stripe, 1 one-sided delta, 2 mosaic, 3 two-sided delta |
| route_r_o | output | 2 | Lane for red (3 = off) |
| route_g_o | output | 2 | Lane for green (3 = off) |
| route_b_o | output | 2 | Lane for blue (3 = off) |
| bank_sel_o | output | 1 | Active sample-and-hold bank |
| sample_en_o | output | 1 | Sampling permitted (armed) |

## Verification
Every result of this block is due at one fixed edge: the (`SYNC_STAGES`+1)-th rising edge after the inhibit input falls. With the default of two stages, that is the third edge. The latency test drives `inh_i` low just after a falling clock edge. It then samples at the next falling clock edges, expecting the old values after two rising edges and the new ones after three. The other tests wait those three edges plus margin before checking, so each check looks at settled outputs. The expected route codes come from a count of edges that the bench keeps itself and from the pattern in force at the last edge.

// File: rtl/vmx_pkg.sv
// Package: shared types and constants for the video multiplexer sequencer.
// Assumes exactly three colours and three lanes; lane code 3 means "off".
package vmx_pkg;

    localparam int NUM_COLORS   = 3;
    localparam int LANE_W       = 2;
    localparam int MOSAIC_LINES = NUM_COLORS;
    localparam int DELTA_LINES  = 4;
    localparam int MOS_W        = $clog2(MOSAIC_LINES);
    localparam int DLT_W        = $clog2(DELTA_LINES);
    localparam logic [LANE_W-1:0] LANE_OFF = 2'd3;

    typedef enum logic [1:0] {
        PAT_STRIPE    = 2'd0,
        PAT_DELTA_ONE = 2'd1,
        PAT_MOSAIC    = 2'd2,
        PAT_DELTA_TWO = 2'd3
    } pattern_e;

    // Rotate a colour index by a shift, modulo the lane count.
    function automatic logic [LANE_W-1:0] rotate_lane(input logic [LANE_W-1:0] color,
                                                      input logic [LANE_W-1:0] shift);
        logic [LANE_W:0] sum;
        sum = {1'b0, color} + {1'b0, shift};
        if (sum >= (LANE_W+1)'(NUM_COLORS)) sum = sum - (LANE_W+1)'(NUM_COLORS);
        return sum[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/vmx_inh_edge.sv
// Module: synchronizes the inhibit input and flags its falling edge for one cycle.
// Assumes the inhibit input idles low; the chain resets to low, so a rising edge never
// produces a flag and reset never creates a false falling edge.
module vmx_inh_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inh_i,
    output logic fall_o
);

    logic inh_s;
    logic inh_p;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign inh_s = inh_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            // Shift the asynchronous input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], inh_i} & {SYNC_STAGES{1'b1}};
            end
            assign inh_s = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) inh_p <= 1'b0;
        else        inh_p <= inh_s;
    end

    assign fall_o = inh_p & ~inh_s;

    // R10: a falling edge flag lasts one cycle only.
    assert_single_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/vmx_mod_counter.sv
// Module: modulo-N line counter stepping on a one-cycle strobe.
// Exposes both the registered count and the value it takes at the next edge, so that
// downstream registers can be loaded in the same cycle. Assumes MODULUS >= 2.
module vmx_mod_counter #(
    parameter int MODULUS = 3,
    localparam int CNT_W  = (MODULUS > 2) ? $clog2(MODULUS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_nxt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

    // Work out the following count: wrap at the last value, hold without a strobe.
    always_comb begin
        if (!step_i)              count_nxt_o = count_o;
        else if (count_o == LAST) count_nxt_o = '0;
        else                      count_nxt_o = count_o + 1'b1;
    end

    // Hold the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_nxt_o;
    end

    // R6: the count never leaves its range.
    assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= LAST);

    // R4: without a strobe the count holds.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(count_o));

endmodule

// File: rtl/vmx_route_map.sv
// Module: maps the line counters and colour-filter arrangement to a lane for each colour.
// Purely combinational; assumes mos_phase_i < 3 and dlt_phase_i < 4.
module vmx_route_map
    import vmx_pkg::*;
(
    input  pattern_e                              pattern_i,
    input  logic [MOS_W-1:0]                      mos_phase_i,
    input  logic [DLT_W-1:0]                      dlt_phase_i,
    output logic [NUM_COLORS-1:0][LANE_W-1:0]     lane_o
);

    logic [LANE_W-1:0] shift;

    // Pick the rotation amount for the current line from the arrangement.
    always_comb begin
        unique case (pattern_i)
            PAT_STRIPE:    shift = '0;
            PAT_MOSAIC:    shift = LANE_W'(mos_phase_i);
            PAT_DELTA_ONE: shift = dlt_phase_i[0] ? 2'd1 : 2'd0;
            PAT_DELTA_TWO: begin
                if (dlt_phase_i == 2'd1)      shift = 2'd1;
                else if (dlt_phase_i == 2'd3) shift = 2'd2;
                else                          shift = 2'd0;
            end
            default:       shift = '0;
        endcase
    end

    generate
        for (genvar c = 0; c < NUM_COLORS; c++) begin : g_color
            // Rotate this colour's home lane by the line shift.
            always_comb lane_o[c] = rotate_lane(LANE_W'(c), shift);
        end
    endgenerate

endmodule

// File: rtl/vmx_select_seq.sv
// Module: top of the video multiplexer select sequencer.
// Steps the line counters and the bank selector on each inhibit falling edge, and
// registers the routing pattern for that line. Holds the multiplexer off and sampling
// disabled from reset until the first edge. Assumes pat_sel_i is steady around the edge.
module vmx_select_seq
    import vmx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inh_i,
    input  logic [1:0]        pat_sel_i,
    output logic [LANE_W-1:0] route_r_o,
    output logic [LANE_W-1:0] route_g_o,
    output logic [LANE_W-1:0] route_b_o,
    output logic              bank_sel_o,
    output logic              sample_en_o
);

    logic                           fall;
    logic [MOS_W-1:0]               mos_q, mos_nxt;
    logic [DLT_W-1:0]               dlt_q, dlt_nxt;
    logic                           bank_nxt;
    logic [NUM_COLORS-1:0][LANE_W-1:0] lane_nxt;
    logic [NUM_COLORS-1:0][LANE_W-1:0] route_q;
    pattern_e                       pat_q;
    logic                           armed_q;

    vmx_inh_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .inh_i  (inh_i),
        .fall_o (fall)
    );

    vmx_mod_counter #(.MODULUS(MOSAIC_LINES)) u_mos_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (fall),
        .count_o     (mos_q),
        .count_nxt_o (mos_nxt)
    );

    vmx_mod_counter #(.MODULUS(DELTA_LINES)) u_dlt_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (fall),
        .count_o     (dlt_q),
        .count_nxt_o (dlt_nxt)
    );

    vmx_mod_counter #(.MODULUS(2)) u_bank_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (fall),
        .count_o     (bank_sel_o),
        .count_nxt_o (bank_nxt)
    );

    vmx_route_map u_map (
        .pattern_i   (pattern_e'(pat_sel_i)),
        .mos_phase_i (mos_nxt),
        .dlt_phase_i (dlt_nxt),
        .lane_o      (lane_nxt)
    );

    // Arm sampling at the first line boundary and keep it armed.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed_q <= 1'b0;
        else if (fall) armed_q <= 1'b1;
    end

    // Load the routing and the arrangement for the new line at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= {NUM_COLORS{LANE_OFF}};
            pat_q   <= PAT_STRIPE;
        end else if (fall) begin
            route_q <= lane_nxt;
            pat_q   <= pattern_e'(pat_sel_i);
        end
    end

    assign route_r_o   = route_q[0];
    assign route_g_o   = route_q[1];
    assign route_b_o   = route_q[2];
    assign sample_en_o = armed_q;

    // R2: before arming, the multiplexer is off and bank 0 is selected.
    assert_off_before_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en_o |-> (route_r_o == LANE_OFF && route_g_o == LANE_OFF &&
                          route_b_o == LANE_OFF && !bank_sel_o));

    // R3: once armed, sampling stays enabled.
    assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |=> sample_en_o);

    // R4: each line boundary swaps the bank.
    assert_bank_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> bank_sel_o != $past(bank_sel_o));

    // R5: stripe arrangement routes every colour to its home lane.
    assert_stripe_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en_o && pat_q == PAT_STRIPE) |->
        (route_r_o == 2'd0 && route_g_o == 2'd1 && route_b_o == 2'd2));

    // R6: once armed, the three colours occupy three different live lanes.
    assert_distinct_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |-> (route_r_o != route_g_o && route_g_o != route_b_o &&
                         route_r_o != route_b_o && route_r_o != LANE_OFF &&
                         route_g_o != LANE_OFF && route_b_o != LANE_OFF));

    // R9: routing changes only at a line boundary.
    assert_route_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(route_q));

endmodule

// File: tb/vmx_select_seq_bench.sv
module vmx_select_seq_bench;

    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inh = 1'b0;
    logic [1:0] pat = 2'd0;
    logic [1:0] rr, rg, rb;
    logic       bank, en;

    int n_checks = 0;
    int n_fail   = 0;
    int edges    = 0;     // falling edges since reset
    logic [1:0] pat_at_edge = 2'd0;

    always #10 clk = ~clk;   // 50 MHz

    vmx_select_seq #(.SYNC_STAGES(S)) u_vmx_select_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .inh_i       (inh),
        .pat_sel_i   (pat),
        .route_r_o   (rr),
        .route_g_o   (rg),
        .route_b_o   (rb),
        .bank_sel_o  (bank),
        .sample_en_o (en)
    );

    function automatic logic [1:0] exp_lane(input logic [1:0] p, input int n, input int c);
        int sh;
        if (n == 0) return 2'd3;
        case (p)
            2'd0: sh = 0;
            2'd2: sh = n % 3;
            2'd1: sh = (n % 2 == 1) ? 1 : 0;
            default: sh = (n % 4 == 1) ? 1 : ((n % 4 == 3) ? 2 : 0);
        endcase
        return 2'((c + sh) % 3);
    endfunction

    task automatic check1(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check1(req, "route_r", rr, exp_lane(pat_at_edge, edges, 0));
        check1(req, "route_g", rg, exp_lane(pat_at_edge, edges, 1));
        check1(req, "route_b", rb, exp_lane(pat_at_edge, edges, 2));
        check1(req, "bank", bank, edges % 2);
        check1(req, "sample_en", en, (edges > 0) ? 1 : 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        inh = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        edges = 0;
        pat_at_edge = 2'd0;
        @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk);
        inh = 1'b1;
        repeat (4) @(negedge clk);
        inh = 1'b0;
        repeat (S + 2) @(negedge clk);
        edges++;
        pat_at_edge = pat;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        check_all("R1");
    endtask

    // R2, R3, R10: no effect before first fall; exact latency of first fall
    task automatic t_first_edge();
        do_reset();
        pat = 2'd2;
        @(negedge clk);
        inh = 1'b1;
        repeat (8) @(negedge clk);
        check_all("R2");
        inh = 1'b0;
        repeat (S) @(negedge clk);
        check1("R10", "sample_en before due edge", en, 0);
        check1("R10", "route_r before due edge", rr, 3);
        @(negedge clk);
        edges = 1;
        pat_at_edge = pat;
        check1("R10", "sample_en at due edge", en, 1);
        check_all("R3");
        repeat (20) @(negedge clk);
        check1("R3", "sample_en held", en, 1);
    endtask

    // R5: stripe
    task automatic t_stripe();
        do_reset();
        pat = 2'd0;
        for (int i = 0; i < 5; i++) begin
            pulse();
            check_all("R5");
        end
    endtask

    // R6 and R4: mosaic rotation and bank alternation
    task automatic t_mosaic();
        do_reset();
        pat = 2'd2;
        for (int i = 0; i < 7; i++) begin
            pulse();
            check_all("R6");
            check1("R4", "bank", bank, edges % 2);
        end
    endtask

    // R7: one-sided delta
    task automatic t_delta_one();
        do_reset();
        pat = 2'd1;
        for (int i = 0; i < 4; i++) begin
            pulse();
            check_all("R7");
        end
    endtask

    // R8: two-sided delta
    task automatic t_delta_two();
        do_reset();
        pat = 2'd3;
        for (int i = 0; i < 8; i++) begin
            pulse();
            check_all("R8");
        end
    endtask

    // R9: pattern changes between edges are ignored until the next edge
    task automatic t_latch();
        do_reset();
        pat = 2'd2;
        pulse();
        pulse();
        pat = 2'd0;
        repeat (10) @(negedge clk);
        check_all("R9");
        pulse();
        check_all("R9");
    endtask

    // R11: reset in mid-run restarts counting
    task automatic t_midreset();
        do_reset();
        pat = 2'd2;
        pulse();
        pulse();
        do_reset();
        check_all("R11");
        pat = 2'd2;
        pulse();
        check_all("R11");
    endtask

    initial begin
        t_reset();
        t_first_edge();
        t_stripe();
        t_mosaic();
        t_delta_one();
        t_delta_two();
        t_latch();
        t_midreset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule